// File: doc/BRIEF.md
# Command-Response Buffer Control Registers

This block is the register front end of a secure-module command interface. A host reaches it over a plain 32-bit write/read bus. Through it the host claims and releases a locality, moves the module between ready and idle, and sets the addresses and sizes of the command and response areas. It also rings the start and cancel doorbells. The block does not run commands. When a start is accepted, it sends a one-cycle request to a backend engine and keeps the start bit set. It then waits for a completion pulse with a success flag, clears the start bit, and on failure latches a sticky error flag.

The host address carries the locality above bit 12; the low 12 bits select the register. Offsets at 0x80 and above belong to the data buffer, which lives elsewhere, so this block ignores them. Reads are combinational from `bus_addr` and have no side effects. The backend signals carry no payload, so they are plain single-cycle pulses rather than a valid/ready stream. The engine must give exactly one `be_done` for each `be_req`. No back-pressure exists on either side.

Top module: `crb_regif`

## Requirements
- R1: After reset, the locality state word (offset 0x00) reads 0x80 ORed with the forced established bit. The control status word (0x44) reads 0x2: bit 1 is idle = 1 and bit 0 is error = 0. The interface ID (0x30) reads 0x00025811. Interface ID 2 (0x34) reads the VENDOR_ID parameter in bits 15:0 (default 0x1D5A) and zero above.
- R2: After reset, command low address (0x5C) and response address (0x68) read BASE_ADDR+0x80. Command size (0x58) and response size (0x64) read APERTURE−0x80. Command high address (0x60) reads 0. All five accept full 32-bit writes and read them back.
- R3: Writing exactly 1 to locality control (0x08) sets granted (0x0C bit 0), clears been-seized (0x0C bit 1) and sets locality assigned (0x00 bit 1).
- R4: Writing exactly 2 to locality control clears assigned and granted. Writing 8, or any other value, leaves locality state and status unchanged.
- R5: Writing 1 to control request (0x40) clears idle, and writing 2 sets it. Any other value changes nothing.
- R6: A write of 1 to start (0x4C) is accepted only when the start bit is clear, locality is assigned, and the writer locality (address bits ADDR_W−1:12) equals the active locality (0x00 bits 4:2, which stays 0). On acceptance, 0x4C reads 1 from the next cycle. `be_req` is high for exactly that one cycle. The start bit stays set until completion.
- R7: A start write made while unassigned, from another locality, with a value other than 1, or while a start is pending, gives no `be_req` and leaves the start bit unchanged.
- R8: A `be_done` pulse while start is set clears the start bit on the next cycle. If `be_ok` is low, it also sets error (0x44 bit 0), which stays set until reset. A `be_done` pulse with no start pending changes nothing.
- R9: Writing 1 to cancel (0x48) while start is set gives a one-cycle `be_cancel` on the next cycle. At any other time, a cancel write gives no pulse.
- R10: Bit 0 of the locality state read is 1 whenever `be_established` is low, and 0 when it is high.
- R11: Reads of undefined offsets, including the write-only locality control, control request, cancel and 0x80 and above, return 0. Writes to undefined offsets and to 0x80 and above change no readable state.
- R12: Writes to the read-only words (0x00, 0x0C, 0x30, 0x34, 0x44) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Byte address; bits 11:0 offset, upper bits locality |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| be_req | output | 1 | One-cycle command request to the backend |
| be_cancel | output | 1 | One-cycle cancel request to the backend |
| be_done | input | 1 | Backend completion pulse |
| be_ok | input | 1 | Completion success, valid with be_done |
| be_established | input | 1 | Backend established indication |

## Verification
Every piece of state reaches a port without delay. Suppose a locality, idle, start or error flag holds the wrong value. The next read of its word shows the fault in the same cycle, because the read path has no registers. A wrong pending flag shows up in a different way. It appears one cycle later as a missing or extra `be_req` or `be_cancel`, or as a second request that should have been refused. The bench compares both pulse outputs against its model on every clock, so such a fault is flagged on the first cycle it affects.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 12;
  localparam int N_CFG  = 5;

  localparam logic [OFF_W-1:0] OFF_LOC_STATE = 12'h000;
  localparam logic [OFF_W-1:0] OFF_LOC_CTRL  = 12'h008;
  localparam logic [OFF_W-1:0] OFF_LOC_STS   = 12'h00C;
  localparam logic [OFF_W-1:0] OFF_IF_ID     = 12'h030;
  localparam logic [OFF_W-1:0] OFF_IF_ID2    = 12'h034;
  localparam logic [OFF_W-1:0] OFF_CTRL_REQ  = 12'h040;
  localparam logic [OFF_W-1:0] OFF_CTRL_STS  = 12'h044;
  localparam logic [OFF_W-1:0] OFF_CANCEL    = 12'h048;
  localparam logic [OFF_W-1:0] OFF_START     = 12'h04C;
  localparam logic [OFF_W-1:0] OFF_BUF       = 12'h080;

  localparam logic [DATA_W-1:0] IF_ID_VALUE  = 32'h0002_5811;

  typedef enum logic [2:0] {CFG_CSIZE, CFG_CLO, CFG_CHI, CFG_RSIZE, CFG_RADDR} cfg_idx_e;

  function automatic logic [OFF_W-1:0] cfg_offset(input int i);
    case (i)
      0:       return 12'h058;
      1:       return 12'h05C;
      2:       return 12'h060;
      3:       return 12'h064;
      default: return 12'h068;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] cfg_reset(input int i,
      input logic [DATA_W-1:0] base, input logic [DATA_W-1:0] aper);
    case (i)
      0, 3:    return aper - {20'd0, OFF_BUF};
      2:       return '0;
      default: return base + {20'd0, OFF_BUF};
    endcase
  endfunction
endpackage

// File: rtl/crb_locality.sv
module crb_locality
  import crb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              assigned,
  output logic              granted,
  output logic              seized
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assigned <= 1'b0;
      granted  <= 1'b0;
      seized   <= 1'b0;
    end else if (ctrl_hit) begin
      case (wdata)
        32'd1: begin
          assigned <= 1'b1;
          granted  <= 1'b1;
          seized   <= 1'b0;
        end
        32'd2: begin
          assigned <= 1'b0;
          granted  <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crb_cmd_ctrl.sv
module crb_cmd_ctrl
  import crb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_hit,
  input  logic              start_hit,
  input  logic              cancel_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              loc_ok,
  input  logic              be_done,
  input  logic              be_ok,
  output logic              idle,
  output logic              err,
  output logic              start_q,
  output logic              be_req,
  output logic              be_cancel
);
  logic one_val;
  assign one_val = (wdata == 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle      <= 1'b1;
      err       <= 1'b0;
      start_q   <= 1'b0;
      be_req    <= 1'b0;
      be_cancel <= 1'b0;
    end else begin
      be_req    <= 1'b0;
      be_cancel <= 1'b0;
      if (req_hit) begin
        if (one_val)                 idle <= 1'b0;
        else if (wdata == 32'd2)     idle <= 1'b1;
      end
      if (start_hit && one_val && !start_q && loc_ok) begin
        start_q <= 1'b1;
        be_req  <= 1'b1;
      end
      if (cancel_hit && one_val && start_q)
        be_cancel <= 1'b1;
      if (start_q && be_done) begin
        start_q <= 1'b0;
        if (!be_ok) err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crb_cfg_regs.sv
module crb_cfg_regs
  import crb_pkg::*;
#(
  parameter logic [DATA_W-1:0] BASE_ADDR = 32'hFED4_0000,
  parameter logic [DATA_W-1:0] APERTURE  = 32'h0000_1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [OFF_W-1:0]             off,
  input  logic [DATA_W-1:0]            wdata,
  output logic [N_CFG-1:0][DATA_W-1:0] cfg
);
  for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
    localparam logic [OFF_W-1:0]  MY_OFF = cfg_offset(i);
    localparam logic [DATA_W-1:0] MY_RST = cfg_reset(i, BASE_ADDR, APERTURE);
    always_ff @(posedge clk) begin
      if (!rst_n)                      cfg[i] <= MY_RST;
      else if (wr_en && off == MY_OFF) cfg[i] <= wdata;
    end
  end
endmodule

// File: rtl/crb_regif.sv
module crb_regif
  import crb_pkg::*;
#(
  parameter int                ADDR_W    = 15,
  parameter logic [31:0]       BASE_ADDR = 32'hFED4_0000,
  parameter logic [31:0]       APERTURE  = 32'h0000_1000,
  parameter logic [15:0]       VENDOR_ID = 16'h1D5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              be_req,
  output logic              be_cancel,
  input  logic              be_done,
  input  logic              be_ok,
  input  logic              be_established
);
  localparam int LOC_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0] off;
  logic [LOC_W-1:0] writer_loc;
  logic             reg_wr;
  logic             assigned, granted, seized;
  logic             idle, err, start_q, loc_ok;
  logic [2:0]       active_loc;
  logic [N_CFG-1:0][DATA_W-1:0] cfg;

  assign off        = bus_addr[OFF_W-1:0];
  assign writer_loc = bus_addr[ADDR_W-1:OFF_W];
  assign reg_wr     = bus_wr && (off < OFF_BUF);
  assign active_loc = 3'd0;
  assign loc_ok     = assigned && (writer_loc == LOC_W'(active_loc));

  crb_locality u_loc (
    .clk(clk), .rst_n(rst_n),
    .ctrl_hit(reg_wr && off == OFF_LOC_CTRL),
    .wdata(bus_wdata),
    .assigned(assigned), .granted(granted), .seized(seized)
  );

  crb_cmd_ctrl u_cmd (
    .clk(clk), .rst_n(rst_n),
    .req_hit(reg_wr && off == OFF_CTRL_REQ),
    .start_hit(reg_wr && off == OFF_START),
    .cancel_hit(reg_wr && off == OFF_CANCEL),
    .wdata(bus_wdata), .loc_ok(loc_ok),
    .be_done(be_done), .be_ok(be_ok),
    .idle(idle), .err(err), .start_q(start_q),
    .be_req(be_req), .be_cancel(be_cancel)
  );

  crb_cfg_regs #(.BASE_ADDR(BASE_ADDR), .APERTURE(APERTURE)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .off(off), .wdata(bus_wdata), .cfg(cfg)
  );

  always_comb begin
    bus_rdata = '0;
    case (off)
      OFF_LOC_STATE: bus_rdata = {24'd0, 1'b1, 2'b00, active_loc, assigned, ~be_established};
      OFF_LOC_STS:   bus_rdata = {30'd0, seized, granted};
      OFF_IF_ID:     bus_rdata = IF_ID_VALUE;
      OFF_IF_ID2:    bus_rdata = {16'd0, VENDOR_ID};
      OFF_CTRL_STS:  bus_rdata = {30'd0, idle, err};
      OFF_START:     bus_rdata = {31'd0, start_q};
      default: begin
        for (int i = 0; i < N_CFG; i++)
          if (off == cfg_offset(i)) bus_rdata = cfg[i];
      end
    endcase
  end
endmodule

// File: rtl/crb_regif_chk.sv
module crb_regif_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              be_req,
  input logic              be_cancel,
  input logic              be_done,
  input logic              be_ok,
  input logic              start_q,
  input logic              assigned,
  input logic              err
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |=> !be_req); // R6
  AST_REQ_FROM_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> $past(bus_wr && bus_addr[11:0] == 12'h04C && bus_wdata == 32'd1)); // R6
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !be_done) |=> start_q); // R6
  AST_REQ_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> $past(assigned && !start_q)); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && be_done) |=> !start_q); // R8
  AST_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && be_done && !be_ok) |=> err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
  AST_CANCEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    be_cancel |-> $past(start_q)); // R9
endmodule

bind crb_regif crb_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .be_req(be_req), .be_cancel(be_cancel),
  .be_done(be_done), .be_ok(be_ok), .start_q(start_q),
  .assigned(assigned), .err(err)
);

// File: tb/sim_crb_regif.sv
module sim_crb_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        be_req, be_cancel;
  logic        be_done = 1'b0, be_ok = 1'b0, be_established = 1'b0;

  int n_run = 0, n_fail = 0, cyc = 0;

  // behavioural reference state
  bit m_assigned, m_granted, m_seized, m_idle = 1, m_err, m_start;
  bit x_req, x_cancel;
  logic [31:0] m_cfg [int];

  crb_regif u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .be_req(be_req), .be_cancel(be_cancel),
    .be_done(be_done), .be_ok(be_ok), .be_established(be_established));

  always #10 clk = ~clk;

  task automatic model_reset();
    m_assigned = 0; m_granted = 0; m_seized = 0; m_idle = 1; m_err = 0; m_start = 0;
    x_req = 0; x_cancel = 0;
    m_cfg[12'h058] = 32'h0000_0F80; m_cfg[12'h05C] = 32'hFED4_0080;
    m_cfg[12'h060] = 32'h0;         m_cfg[12'h064] = 32'h0000_0F80;
    m_cfg[12'h068] = 32'hFED4_0080;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else begin
      logic [11:0] o; logic [2:0] l; bit pend;
      o = bus_addr[11:0]; l = bus_addr[14:12]; pend = m_start;
      x_req = 0; x_cancel = 0;
      if (bus_wr && o < 12'h080) begin
        if (o == 12'h008 && bus_wdata == 1) begin m_assigned = 1; m_granted = 1; m_seized = 0; end
        if (o == 12'h008 && bus_wdata == 2) begin m_assigned = 0; m_granted = 0; end
        if (o == 12'h040 && bus_wdata == 1) m_idle = 0;
        if (o == 12'h040 && bus_wdata == 2) m_idle = 1;
        if (o == 12'h04C && bus_wdata == 1 && !pend && m_assigned && l == 0) begin
          m_start = 1; x_req = 1;
        end
        if (o == 12'h048 && bus_wdata == 1 && pend) x_cancel = 1;
        if (m_cfg.exists(int'(o))) m_cfg[int'(o)] = bus_wdata;
      end
      if (be_done && pend) begin m_start = 0; if (!be_ok) m_err = 1; end
    end
  end

  // per-cycle pulse comparison (R6, R7, R9)
  always @(negedge clk) if (rst_n) begin
    n_run++;
    if (be_req !== x_req || be_cancel !== x_cancel) begin
      n_fail++;
      $display("FAIL R6/R7/R9 cycle %0d: req=%b cancel=%b expected req=%b cancel=%b",
               cyc, be_req, be_cancel, x_req, x_cancel);
    end
  end

  function automatic logic [31:0] exp_rd(logic [11:0] o);
    case (o)
      12'h000: return 32'h80 | (32'(m_assigned) << 1) | 32'(!be_established);
      12'h00C: return (32'(m_seized) << 1) | 32'(m_granted);
      12'h030: return 32'h0002_5811;
      12'h034: return 32'h0000_1D5A;
      12'h044: return (32'(m_idle) << 1) | 32'(m_err);
      12'h04C: return 32'(m_start);
      default: return m_cfg.exists(int'(o)) ? m_cfg[int'(o)] : 32'h0;
    endcase
  endfunction

  task automatic rd(input logic [14:0] a, input string req);
    @(negedge clk); bus_addr = a; #1;
    n_run++;
    if (bus_rdata !== exp_rd(a[11:0])) begin
      n_fail++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, bus_rdata, exp_rd(a[11:0]));
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic done(input bit ok);
    @(negedge clk); be_done = 1; be_ok = ok;
    @(negedge clk); be_done = 0;
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R2 / R10 reset values, established low forces bit 0
    rd(15'h000, "R1"); rd(15'h044, "R1"); rd(15'h030, "R1"); rd(15'h034, "R1");
    rd(15'h058, "R2"); rd(15'h05C, "R2"); rd(15'h060, "R2"); rd(15'h064, "R2"); rd(15'h068, "R2");
    be_established = 1; rd(15'h000, "R10");
    // R7 start while unassigned
    wr(15'h04C, 1); rd(15'h04C, "R7");
    // R4 ignored values
    wr(15'h008, 8); rd(15'h00C, "R4"); wr(15'h008, 5); rd(15'h000, "R4");
    // R3 request
    wr(15'h008, 1); rd(15'h00C, "R3"); rd(15'h000, "R3");
    // R12 read-only
    wr(15'h044, 32'h0); wr(15'h030, 32'hFFFF_FFFF); wr(15'h00C, 32'h0);
    rd(15'h044, "R12"); rd(15'h030, "R12"); rd(15'h00C, "R12");
    // R11 undefined and buffer offsets
    wr(15'h010, 32'hDEAD_BEEF); wr(15'h0D8, 32'h1234); wr(15'h058 | 15'h080, 32'h55);
    rd(15'h010, "R11"); rd(15'h008, "R11"); rd(15'h0D8, "R11"); rd(15'h058, "R11");
    // R5 control request
    wr(15'h040, 1); rd(15'h044, "R5"); wr(15'h040, 3); rd(15'h044, "R5");
    wr(15'h040, 2); rd(15'h044, "R5");
    // R2 config writes
    wr(15'h05C, 32'hA5A5_0000); wr(15'h060, 32'h0000_0001); wr(15'h068, 32'h1357_9BDF);
    rd(15'h05C, "R2"); rd(15'h060, "R2"); rd(15'h068, "R2");
    // R7 wrong locality, wrong value; R9 cancel with nothing pending
    wr(15'h104C, 1); wr(15'h04C, 3); wr(15'h048, 1); rd(15'h04C, "R7");
    // R6 accepted start, R7 repeat refused, R9 cancel
    wr(15'h04C, 1); rd(15'h04C, "R6");
    wr(15'h04C, 1); wr(15'h048, 1); rd(15'h04C, "R6");
    // R8 success completion
    done(1); rd(15'h04C, "R8"); rd(15'h044, "R8");
    // R8 failing completion, sticky error, spurious done
    wr(15'h04C, 1); done(0); rd(15'h044, "R8"); rd(15'h04C, "R8");
    done(1); rd(15'h044, "R8");
    // R4 relinquish then start refused (R7)
    wr(15'h008, 2); rd(15'h000, "R4"); rd(15'h00C, "R4");
    wr(15'h04C, 1); rd(15'h04C, "R7");
    be_established = 0; rd(15'h000, "R10");
    repeat (3) @(negedge clk);
    finish_up();
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule